// File: doc/BRIEF.md
# Link Adaptor Host Register Interface

This block connects a byte-wide microprocessor bus to a serial link engine. The host sees four registers: a received-byte register, a receive status register, a transmit byte register and a transmit status register. Two interrupt lines report the state of each direction. The link engine's framing and bit-level logic sit outside the block and are reached through plain strobes.

Flow control is set at link level. When the host writes a byte, a transmission starts and the transmit side goes busy. It becomes ready again only after the engine reports that the byte has gone out and an acknowledge has come back on the receive link; the two events may arrive in either order. On the receive side, a byte arriving from the link is held and flagged. When the host reads that byte, the flag clears and the block asks the engine to send an acknowledge to the far end. The host can either use the interrupts or poll the status registers.

Registers are selected by a 2-bit code: 0 is received byte (read only), 1 is transmit byte (write only), 2 is receive status and 3 is transmit status. Status bit layout: bit 0 is the flag (byte present on receive, ready on transmit), bit 1 is the interrupt enable, and receive status bit 2 is a sticky overrun bit. All other bits read zero. Read data is combinational from the select lines. Strobes and link inputs are sampled on the rising clock edge.

Top module: `link_host_regs`

## Requirements
- R1: After reset, receive status reads 0x00, transmit status reads 0x01, both interrupts are low and link_ack_req and link_tx_start are low.
- R2: In both status registers only bit 1 (interrupt enable) is writable. Bits other than 0, 1 and receive bit 2 read zero. Selecting register 1 reads 0x00.
- R3: in_irq is high exactly when the byte-present flag (receive status bit 0) and the receive enable (bit 1) are both set.
- R4: out_irq is high exactly when transmit ready (transmit status bit 0) and the transmit enable (bit 1) are both set. It stays low with the enable clear.
- R5: A link_rx_valid pulse while no byte is present stores link_rx_data, readable at register 0, and sets the byte-present flag after that edge.
- R6: A host read of register 0 with a byte present clears the flag and pulses link_ack_req high for exactly the cycle after the read edge. A read with no byte present raises no acknowledge request.
- R7: A host write to register 1 while ready clears ready and pulses link_tx_start for one cycle, with link_tx_data holding the written byte.
- R8: Once busy, ready returns only after both link_tx_done and link_ack_rcvd have been seen, in either order or in the same cycle. Either event arriving while ready is discarded.
- R9: A host write to register 1 while busy is ignored: no link_tx_start, and link_tx_data is unchanged.
- R10: A link byte arriving while a byte is present, and not in the same cycle as a read of register 0, is dropped, and receive status bit 2 is set and stays set. A byte arriving in the same cycle as that read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data (combinational) |
| in_irq | output | 1 | Receive interrupt |
| out_irq | output | 1 | Transmit interrupt |
| link_rx_valid | input | 1 | Received byte strobe |
| link_rx_data | input | DW | Received byte |
| link_ack_req | output | 1 | Request to send an acknowledge packet |
| link_tx_start | output | 1 | Start transmitting link_tx_data |
| link_tx_data | output | DW | Byte to transmit |
| link_tx_done | input | 1 | Byte transmission completed |
| link_ack_rcvd | input | 1 | Acknowledge packet received |

## Verification
The bench drives the acknowledge before, after and in the same cycle as transmit completion. A design that re-arms on either event alone raises ready too early, and one that needs a fixed order stays busy forever. It also sends a stale completion while the transmit side is idle: a design that latches it would report ready after the acknowledge alone. It checks that a write while busy does not start a second transmission or change the byte, and that a byte arriving together with the host read replaces the old one rather than being reported as an overrun. The polling path is covered with both enables clear, where a design that gates the flags rather than the interrupts would hide the status bits.

// File: rtl/link_host_regs.sv
module link_host_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_sel,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          in_irq,
  output logic          out_irq,
  input  logic          link_rx_valid,
  input  logic [DW-1:0] link_rx_data,
  output logic          link_ack_req,
  output logic          link_tx_start,
  output logic [DW-1:0] link_tx_data,
  input  logic          link_tx_done,
  input  logic          link_ack_rcvd
);
  localparam logic [1:0] SEL_DIN = 2'd0, SEL_DOUT = 2'd1, SEL_ISTAT = 2'd2, SEL_OSTAT = 2'd3;
  localparam int PADW = DW - 3;

  logic [DW-1:0] rx_byte;
  logic data_pres, in_ien, overrun;
  logic out_rdy, out_ien, done_seen, ack_seen;
  logic rd_din, wr_dout, take_rx, done_now, ack_now;

  assign rd_din   = host_rd && (host_sel == SEL_DIN);
  assign wr_dout  = host_wr && (host_sel == SEL_DOUT);
  assign take_rx  = link_rx_valid && (!data_pres || rd_din);
  assign done_now = done_seen || link_tx_done;
  assign ack_now  = ack_seen || link_ack_rcvd;

  assign in_irq  = data_pres && in_ien;
  assign out_irq = out_rdy && out_ien;

  always_comb begin
    case (host_sel)
      SEL_DIN:   host_rdata = rx_byte;
      SEL_ISTAT: host_rdata = {{PADW{1'b0}}, overrun, in_ien, data_pres};
      SEL_OSTAT: host_rdata = {{PADW{1'b0}}, 1'b0, out_ien, out_rdy};
      default:   host_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_byte       <= '0;
      data_pres     <= 1'b0;
      in_ien        <= 1'b0;
      overrun       <= 1'b0;
      out_rdy       <= 1'b1;
      out_ien       <= 1'b0;
      done_seen     <= 1'b0;
      ack_seen      <= 1'b0;
      link_ack_req  <= 1'b0;
      link_tx_start <= 1'b0;
      link_tx_data  <= '0;
    end else begin
      if (take_rx) begin
        rx_byte   <= link_rx_data;
        data_pres <= 1'b1;
      end else if (rd_din) begin
        data_pres <= 1'b0;
      end
      if (link_rx_valid && !take_rx) overrun <= 1'b1;
      link_ack_req <= rd_din && data_pres;

      if (host_wr && host_sel == SEL_ISTAT) in_ien  <= host_wdata[1];
      if (host_wr && host_sel == SEL_OSTAT) out_ien <= host_wdata[1];

      link_tx_start <= 1'b0;
      if (out_rdy) begin
        if (wr_dout) begin
          out_rdy       <= 1'b0;
          link_tx_start <= 1'b1;
          link_tx_data  <= host_wdata;
        end
      end else if (done_now && ack_now) begin
        out_rdy   <= 1'b1;
        done_seen <= 1'b0;
        ack_seen  <= 1'b0;
      end else begin
        done_seen <= done_now;
        ack_seen  <= ack_now;
      end
    end
  end
endmodule

// File: rtl/link_host_regs_chk.sv
module link_host_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] host_sel,
  input logic       host_rd,
  input logic       host_wr,
  input logic       link_rx_valid,
  input logic       link_tx_done,
  input logic       link_ack_rcvd,
  input logic       link_tx_start,
  input logic       link_ack_req,
  input logic       out_irq,
  input logic       out_rdy,
  input logic       data_pres
);
  // R7
  start_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == 2'd1 && out_rdy |=> link_tx_start && !out_rdy && !out_irq);
  // R9
  no_spurious_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == 2'd1 && !out_rdy |=> !link_tx_start);
  // R8
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_rdy && !link_tx_done && !link_ack_rcvd |=> !out_rdy);
  // R6
  ack_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_sel == 2'd0 && data_pres |=> link_ack_req);
  // R6
  no_empty_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_sel == 2'd0 && !data_pres |=> !link_ack_req);
  // R5
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_rx_valid && !data_pres |=> data_pres);
endmodule

bind link_host_regs link_host_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr),
  .link_rx_valid(link_rx_valid), .link_tx_done(link_tx_done), .link_ack_rcvd(link_ack_rcvd),
  .link_tx_start(link_tx_start), .link_ack_req(link_ack_req), .out_irq(out_irq),
  .out_rdy(out_rdy), .data_pres(data_pres)
);

// File: tb/link_host_regs_test.sv
`timescale 1ns/1ps
module link_host_regs_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] host_sel = '0;
  logic host_rd = 1'b0, host_wr = 1'b0, link_rx_valid = 1'b0, link_tx_done = 1'b0, link_ack_rcvd = 1'b0;
  logic [7:0] host_wdata = '0, link_rx_data = '0;
  logic [7:0] host_rdata, link_tx_data;
  logic in_irq, out_irq, link_ack_req, link_tx_start;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  link_host_regs uut (.*);

  // {sel, wdata, expected readback}
  localparam logic [17:0] TBL [6] = '{
    {2'd3, 8'hFF, 8'h03}, {2'd3, 8'h00, 8'h01}, {2'd2, 8'hFF, 8'h02},
    {2'd2, 8'h00, 8'h00}, {2'd2, 8'hFD, 8'h00}, {2'd3, 8'h02, 8'h03}};

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic [1:0] sel, logic rd, logic wr, logic [7:0] wd,
                      logic rxv, logic [7:0] rxd, logic done, logic ack);
    @(negedge clk);
    host_sel = sel; host_rd = rd; host_wr = wr; host_wdata = wd;
    link_rx_valid = rxv; link_rx_data = rxd; link_tx_done = done; link_ack_rcvd = ack;
    @(posedge clk); #1;
    host_rd = 0; host_wr = 0; link_rx_valid = 0; link_tx_done = 0; link_ack_rcvd = 0;
  endtask

  task automatic idle();
    step(2'd0, 0, 0, 8'h00, 0, 8'h00, 0, 0);
  endtask

  task automatic peek(logic [1:0] sel, output logic [7:0] v);
    @(negedge clk); host_sel = sel; #1; v = host_rdata;
  endtask

  task automatic wreg(logic [1:0] sel, logic [7:0] d);
    step(sel, 0, 1, d, 0, 8'h00, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual expired expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    peek(2'd2, v); check("R1 rx status", v, 8'h00);
    peek(2'd3, v); check("R1 tx status", v, 8'h01);
    check("R1 irqs", {6'b0, in_irq, out_irq}, 8'h00);
    check("R1 strobes", {6'b0, link_ack_req, link_tx_start}, 8'h00);

    // R2 status write masks
    foreach (TBL[i]) begin
      wreg(TBL[i][17:16], TBL[i][15:8]);
      peek(TBL[i][17:16], v); check("R2 status readback", v, TBL[i][7:0]);
    end
    peek(2'd1, v); check("R2 tx reg reads zero", v, 8'h00);
    check("R4 out_irq idle with enable", {7'b0, out_irq}, 8'h01);

    // R5 / R3 capture, polling with enable clear
    step(2'd0, 0, 0, 8'h00, 1, 8'hA5, 0, 0);
    peek(2'd2, v); check("R5 byte present", v, 8'h01);
    check("R3 in_irq masked", {7'b0, in_irq}, 8'h00);
    peek(2'd0, v); check("R5 rx byte", v, 8'hA5);
    wreg(2'd2, 8'h02);
    check("R3 in_irq enabled", {7'b0, in_irq}, 8'h01);

    // R10 overrun
    step(2'd0, 0, 0, 8'h00, 1, 8'h3C, 0, 0);
    peek(2'd0, v); check("R10 byte kept", v, 8'hA5);
    peek(2'd2, v); check("R10 overrun set", v, 8'h07);

    // R6 read triggers ack
    step(2'd0, 1, 0, 8'h00, 0, 8'h00, 0, 0);
    check("R6 ack pulse", {7'b0, link_ack_req}, 8'h01);
    check("R6 in_irq cleared", {7'b0, in_irq}, 8'h00);
    peek(2'd2, v); check("R6 flag cleared, R10 sticky", v, 8'h06);
    idle();
    check("R6 ack one cycle", {7'b0, link_ack_req}, 8'h00);
    step(2'd0, 1, 0, 8'h00, 0, 8'h00, 0, 0);
    check("R6 no ack when empty", {7'b0, link_ack_req}, 8'h00);

    // R10 arrival together with read
    step(2'd0, 0, 0, 8'h00, 1, 8'h11, 0, 0);
    step(2'd0, 1, 0, 8'h00, 1, 8'h22, 0, 0);
    check("R10 simultaneous ack", {7'b0, link_ack_req}, 8'h01);
    peek(2'd0, v); check("R10 new byte taken", v, 8'h22);
    peek(2'd2, v); check("R10 still present", v, 8'h07);
    step(2'd0, 1, 0, 8'h00, 0, 8'h00, 0, 0);

    // R7 transmit start
    wreg(2'd1, 8'h5A);
    check("R7 start pulse", {7'b0, link_tx_start}, 8'h01);
    check("R7 tx data", link_tx_data, 8'h5A);
    check("R4 out_irq drops", {7'b0, out_irq}, 8'h00);
    idle();
    check("R7 start one cycle", {7'b0, link_tx_start}, 8'h00);
    peek(2'd3, v); check("R7 busy", v, 8'h02);

    // R9 write while busy
    wreg(2'd1, 8'h77);
    check("R9 no start", {7'b0, link_tx_start}, 8'h00);
    check("R9 data kept", link_tx_data, 8'h5A);

    // R8 done then ack
    step(2'd0, 0, 0, 8'h00, 0, 8'h00, 1, 0);
    peek(2'd3, v); check("R8 done alone", v, 8'h02);
    step(2'd0, 0, 0, 8'h00, 0, 8'h00, 0, 1);
    peek(2'd3, v); check("R8 done+ack ready", v, 8'h03);
    check("R4 out_irq back", {7'b0, out_irq}, 8'h01);

    // R8 ack then done
    wreg(2'd1, 8'h81);
    step(2'd0, 0, 0, 8'h00, 0, 8'h00, 0, 1);
    peek(2'd3, v); check("R8 ack alone", v, 8'h02);
    step(2'd0, 0, 0, 8'h00, 0, 8'h00, 1, 0);
    peek(2'd3, v); check("R8 ack+done ready", v, 8'h03);

    // R8 same cycle
    wreg(2'd1, 8'h99);
    step(2'd0, 0, 0, 8'h00, 0, 8'h00, 1, 1);
    peek(2'd3, v); check("R8 same cycle ready", v, 8'h03);

    // R4 polling path with enable clear
    wreg(2'd3, 8'h00);
    wreg(2'd1, 8'h42);
    step(2'd0, 0, 0, 8'h00, 0, 8'h00, 1, 1);
    peek(2'd3, v); check("R4 polled ready", v, 8'h01);
    check("R4 out_irq masked", {7'b0, out_irq}, 8'h00);

    // R8 stale done while ready is discarded
    step(2'd0, 0, 0, 8'h00, 0, 8'h00, 1, 0);
    wreg(2'd1, 8'h24);
    check("R7 start after stale", {7'b0, link_tx_start}, 8'h01);
    step(2'd0, 0, 0, 8'h00, 0, 8'h00, 0, 1);
    peek(2'd3, v); check("R8 stale done ignored", v, 8'h00);
    step(2'd0, 0, 0, 8'h00, 0, 8'h00, 1, 0);
    peek(2'd3, v); check("R8 ready after fresh done", v, 8'h01);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule